// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This master-side block frees a two-wire serial bus when a slave still drives the data line low after the master lost its state in the middle of a transfer. When asked, and once on its own after reset, it plays a fixed pattern on the clock and data lines. First it issues a start condition. It then gives nine clock pulses with its own data driver released, so that any pending acknowledge or read bit in the slave can finish. Last it issues a stop condition, which returns the slave's interface logic to idle.

Both lines are open-drain: the block only drives low-enables, and external pull-ups make a line high. It reads both lines back through a two-stage synchronizer. After the stop it reports whether the bus came back idle. Every phase lasts a fixed number of system clocks. The sequence has no data transfer, no addressing and no clock-stretching support.

Top module: `bus_recovery_seq`

## Requirements
- R1: When reset is released, a recovery sequence runs with no request. `busy` is high from reset until that first sequence ends.
- R2: Each sequence opens with a start condition. The master pulls SDA low (`sda_oe`=1) while SCL is released (`scl_oe`=0), after a setup phase with both lines released and before any clock pulse.
- R3: Between the start and the stop, the master gives exactly PULSES (default 9) clock pulses. A pulse is a 1-to-0 change of `scl_oe` with `sda_oe`=0.
- R4: While SCL is released during any of the clock pulses, `sda_oe` stays 0.
- R5: The stop follows the last pulse. With SCL held low, the master first pulls SDA low, then releases SCL, then releases SDA while SCL is released. Exactly one stop occurs per sequence.
- R6: Every line phase lasts HALF_PERIOD clocks. From the clock edge that accepts `start_i` to the first cycle with `done` high, (2*PULSES+7)*HALF_PERIOD+2 clock edges pass.
- R7: After the stop, `bus_ok` is set if both synchronized lines read high, and `recovery_failed` is set otherwise. The two are never high together, and both clear when a new sequence is accepted.
- R8: `start_i` asserted while `busy` is high is ignored. The running sequence keeps its length and its single start, and no second sequence follows.
- R9: `done` is high for exactly one cycle, in the cycle `busy` first reads low. `start_i` seen high while idle makes `busy` high on the next cycle.
- R10: The enables are active high, with 0 meaning released. While idle and during reset both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request a recovery sequence (taken only when idle) |
| scl_i | input | 1 | Level seen on the clock line |
| sda_i | input | 1 | Level seen on the data line |
| scl_oe | output | 1 | Pull clock line low when 1 |
| sda_oe | output | 1 | Pull data line low when 1 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| bus_ok | output | 1 | Both lines read high after the last stop |
| recovery_failed | output | 1 | A line read low after the last stop |

## Verification
A wrong sequencer state appears at the enables within one half period. A skipped or extra state changes the count of clock releases seen between start and stop, or moves the edge where `done` rises away from its computed cycle. A data enable left asserted shows up at the next released clock phase as SDA held low while SCL is high. A bad verdict sampling shows up in the flag levels at the same `done` pulse, and a stuck slave model and a held-low clock line force the failure case.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,      // both lines released, bus setup before start
    ST_START,      // SDA low, SCL high: start condition hold
    ST_LATCH,      // SCL pulled low while SDA still low
    ST_LOW,        // SCL low, SDA released
    ST_HIGH,       // SCL released, SDA released
    ST_STOP_LO,    // SCL low, SDA released
    ST_STOP_PREP,  // SCL low, SDA low
    ST_STOP_SCLHI, // SCL released, SDA low
    ST_STOP_REL,   // both released: stop condition
    ST_CHECK       // sample the lines
  } brs_state_e;

  function automatic logic drive_scl(brs_state_e s);
    return (s == ST_LATCH) || (s == ST_LOW) || (s == ST_STOP_LO) ||
           (s == ST_STOP_PREP);
  endfunction

  function automatic logic drive_sda(brs_state_e s);
    return (s == ST_START) || (s == ST_LATCH) || (s == ST_STOP_PREP) ||
           (s == ST_STOP_SCLHI);
  endfunction

endpackage

// File: rtl/brs_rst_sync.sv
module brs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/brs_line_sync.sv
module brs_line_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] line_i,
  output logic [WIDTH-1:0] line_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= 2'b11;
      else        ff_q <= {ff_q[0], line_i[g]};
    end
    assign line_o[g] = ff_q[1];
  end
endmodule

// File: rtl/brs_timer.sv
module brs_timer #(
  parameter int HALF_PERIOD = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick   = run && (cnt_q == LAST);
  assign cnt_en = run || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R6: the phase counter never passes the half-period limit
  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R6: an idle timer restarts from zero
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/brs_fsm.sv
module brs_fsm
  import brs_pkg::*;
#(
  parameter int PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick,
  input  logic scl_s,
  input  logic sda_s,
  output logic run,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done,
  output logic bus_ok,
  output logic recovery_failed
);
  localparam int PCW = $clog2(PULSES + 1);
  localparam logic [PCW-1:0] LAST_PULSE = PCW'(PULSES - 1);
  localparam logic [PCW-1:0] ALL_PULSES = PCW'(PULSES);

  brs_state_e     state_q, state_d;
  logic [PCW-1:0] pulse_q, pulse_d;
  logic           scl_oe_q, sda_oe_q;
  logic           done_q, ok_q, fail_q;
  logic           ok_d, fail_d;
  logic           accept, verdict;

  assign accept  = (state_q == ST_IDLE) && start_i;
  assign verdict = (state_q == ST_CHECK);

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (start_i) state_d = ST_SETUP;
      ST_SETUP:      if (tick) state_d = ST_START;
      ST_START:      if (tick) state_d = ST_LATCH;
      ST_LATCH:      if (tick) state_d = ST_LOW;
      ST_LOW:        if (tick) state_d = ST_HIGH;
      ST_HIGH:       if (tick) state_d = (pulse_q == LAST_PULSE) ? ST_STOP_LO : ST_LOW;
      ST_STOP_LO:    if (tick) state_d = ST_STOP_PREP;
      ST_STOP_PREP:  if (tick) state_d = ST_STOP_SCLHI;
      ST_STOP_SCLHI: if (tick) state_d = ST_STOP_REL;
      ST_STOP_REL:   if (tick) state_d = ST_CHECK;
      ST_CHECK:      state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  // pulse counter advances when a released-clock phase ends
  always_comb begin
    pulse_d = pulse_q;
    if (accept)                              pulse_d = '0;
    else if ((state_q == ST_HIGH) && tick)   pulse_d = pulse_q + 1'b1;
  end

  // verdict flags
  always_comb begin
    ok_d   = ok_q;
    fail_d = fail_q;
    if (accept) begin
      ok_d   = 1'b0;
      fail_d = 1'b0;
    end else if (verdict) begin
      ok_d   = scl_s && sda_s;
      fail_d = !(scl_s && sda_s);
    end
  end

  // registers; reset enters the setup phase so the first run is automatic
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_SETUP;
      pulse_q  <= '0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      pulse_q  <= pulse_d;
      scl_oe_q <= drive_scl(state_d);
      sda_oe_q <= drive_sda(state_d);
      done_q   <= verdict;
      ok_q     <= ok_d;
      fail_q   <= fail_d;
    end
  end

  assign run             = (state_q != ST_IDLE) && (state_q != ST_CHECK);
  assign scl_oe          = scl_oe_q;
  assign sda_oe          = sda_oe_q;
  assign busy            = (state_q != ST_IDLE);
  assign done            = done_q;
  assign bus_ok          = ok_q;
  assign recovery_failed = fail_q;

  // R2: SDA is pulled low under a released clock only before the first pulse
  a_r2_start_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe_q) && !scl_oe_q) |-> (pulse_q == '0));

  // R3: the pulse count never runs past its limit
  a_r3_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q <= ALL_PULSES);

  // R4: every clock release inside the burst leaves SDA released
  a_r4_sda_free: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_oe_q) && (pulse_q < ALL_PULSES)) |-> !sda_oe_q);

  // R5: SDA is released under a released clock only after the full burst
  a_r5_stop_late: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe_q) && !scl_oe_q) |-> (pulse_q == ALL_PULSES));

  // R7: the two verdict flags exclude each other
  a_r7_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_q && fail_q));

  // R8: a request during a run does not restart it
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy && (state_q != ST_SETUP)) |=> (state_q != ST_SETUP));

  // R9: done is a single-cycle pulse seen only when idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);

  // R10: both lines are released while idle
  a_r10_idle_free: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe_q && !sda_oe_q));
endmodule

// File: rtl/bus_recovery_seq.sv
module bus_recovery_seq #(
  parameter int HALF_PERIOD = 250,
  parameter int PULSES      = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done,
  output logic bus_ok,
  output logic recovery_failed
);
  logic       rst_ns;
  logic [1:0] lines_s;
  logic       run, tick;

  brs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  brs_line_sync #(.WIDTH(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_ns),
    .line_i ({scl_i, sda_i}),
    .line_o (lines_s)
  );

  brs_timer #(.HALF_PERIOD(HALF_PERIOD)) u_timer (
    .clk   (clk),
    .rst_n (rst_ns),
    .run   (run),
    .tick  (tick)
  );

  brs_fsm #(.PULSES(PULSES)) u_fsm (
    .clk             (clk),
    .rst_n           (rst_ns),
    .start_i         (start_i),
    .tick            (tick),
    .scl_s           (lines_s[1]),
    .sda_s           (lines_s[0]),
    .run             (run),
    .scl_oe          (scl_oe),
    .sda_oe          (sda_oe),
    .busy            (busy),
    .done            (done),
    .bus_ok          (bus_ok),
    .recovery_failed (recovery_failed)
  );
endmodule

// File: tb/bus_recovery_seq_bench.sv
module bus_recovery_seq_bench;
  localparam int HP      = 6;
  localparam int NP      = 9;
  localparam int RUN_CYC = (2 * NP + 7) * HP + 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start_i;
  logic scl_oe, sda_oe, busy, done, bus_ok, recovery_failed;

  int   checks = 0, failures = 0;
  bit   finished = 0;

  // slave and line model
  int   slave_hold = 0;
  logic slave_arm = 1'b0;
  logic slave_low = 1'b0;
  int   slave_edges = 0;
  logic force_scl = 1'b0;
  logic scl_prev = 1'b1;

  wire scl_bus = !scl_oe && !force_scl;
  wire sda_bus = !sda_oe && !slave_low;

  bus_recovery_seq #(.HALF_PERIOD(HP), .PULSES(NP)) u_bus_recovery_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
    .bus_ok(bus_ok), .recovery_failed(recovery_failed)
  );

  // slave holds SDA low until it has seen slave_hold rising clock edges (-1: forever)
  always @(posedge clk) begin
    if (slave_arm) begin
      slave_low   = (slave_hold != 0);
      slave_edges = 0;
    end else if (slave_low && scl_bus && !scl_prev) begin
      slave_edges = slave_edges + 1;
      if (slave_hold > 0 && slave_edges >= slave_hold) slave_low = 1'b0;
    end
    scl_prev = scl_bus;
  end

  // monitor of the master's enables
  logic mon_clr = 1'b0;
  logic p_scl = 1'b0, p_sda = 1'b0;
  int   starts = 0, stops = 0, falls = 0, bad = 0;
  int   falls_at_start = -1, falls_at_stop = -1;

  always @(negedge clk) begin
    if (mon_clr) begin
      starts = 0; stops = 0; falls = 0; bad = 0;
      falls_at_start = -1; falls_at_stop = -1;
    end else begin
      if (!p_sda && sda_oe && !scl_oe) begin
        starts = starts + 1;
        falls_at_start = falls;
      end
      if (starts > 0 && stops == 0 && p_scl && !scl_oe) falls = falls + 1;
      if (starts > 0 && falls >= 1 && falls <= NP && !scl_oe && sda_oe) bad = bad + 1;
      if (p_sda && !sda_oe && !scl_oe) begin
        stops = stops + 1;
        falls_at_stop = falls;
      end
    end
    p_scl = scl_oe;
    p_sda = sda_oe;
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // checks on the shape of the last sequence
  task automatic check_shape(input string what);
    check_eq({"R2 one start ", what}, starts, 1);
    check_eq({"R2 start before pulses ", what}, falls_at_start, 0);
    check_eq({"R3 pulse count ", what}, falls_at_stop - 1, NP);
    check_eq({"R4 sda released in pulses ", what}, bad, 0);
    check_eq({"R5 one stop ", what}, stops, 1);
  endtask

  task automatic run_seq(input int hold, input bit fscl, input int mid, output int cycles);
    @(negedge clk);
    slave_hold = hold; slave_arm = 1'b1; mon_clr = 1'b1; force_scl = fscl;
    @(negedge clk);
    @(negedge clk);
    slave_arm = 1'b0; mon_clr = 1'b0; start_i = 1'b1;
    cycles = 0;
    while (cycles < 4 * RUN_CYC) begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
      if (cycles == 1) begin
        start_i = 1'b0;
        check_eq("R9 busy after accept", int'(busy), 1);
        check_eq("R7 flags cleared on accept", int'(bus_ok) + int'(recovery_failed), 0);
      end
      if (mid > 0 && cycles == mid)     start_i = 1'b1;
      if (mid > 0 && cycles == mid + 1) start_i = 1'b0;
      if (done) break;
    end
    check_eq("R9 done reached", int'(done), 1);
    check_eq("R9 busy low with done", int'(busy), 0);
    @(negedge clk);
    check_eq("R9 done one cycle", int'(done), 0);
    force_scl = 1'b0;
  endtask

  initial begin
    int cyc;
    rst_n = 1'b0; start_i = 1'b0;
    slave_hold = 3; slave_arm = 1'b1; mon_clr = 1'b1;
    repeat (3) @(negedge clk);
    // reset state
    check_eq("R10 scl_oe in reset", int'(scl_oe), 0);
    check_eq("R10 sda_oe in reset", int'(sda_oe), 0);
    check_eq("R1 busy in reset", int'(busy), 1);
    check_eq("R9 done in reset", int'(done), 0);
    check_eq("R7 flags in reset", int'(bus_ok) + int'(recovery_failed), 0);
    slave_arm = 1'b0; mon_clr = 1'b0;
    rst_n = 1'b1;
    // R1: automatic run after reset
    cyc = 0;
    while (cyc < 4 * RUN_CYC && !done) begin
      @(negedge clk);
      cyc++;
    end
    check_eq("R1 automatic run finished", int'(done), 1);
    check_shape("auto");
    check_eq("R7 bus_ok after auto", int'(bus_ok), 1);
    @(negedge clk);
    check_eq("R9 done pulse after auto", int'(done), 0);
    check_eq("R10 idle lines released", int'(scl_oe) + int'(sda_oe), 0);

    // sweep slave hold counts, 0 means not stuck
    for (int h = 0; h <= NP; h++) begin
      run_seq(h, 1'b0, 0, cyc);
      check_eq("R6 run length", cyc, RUN_CYC);
      check_shape("sweep");
      check_eq("R7 bus_ok sweep", int'(bus_ok), 1);
      check_eq("R7 no failure sweep", int'(recovery_failed), 0);
    end

    // slave never lets go
    run_seq(-1, 1'b0, 0, cyc);
    check_eq("R6 run length stuck slave", cyc, RUN_CYC);
    check_shape("stuck");
    check_eq("R7 failure stuck sda", int'(recovery_failed), 1);
    check_eq("R7 no ok stuck sda", int'(bus_ok), 0);

    // clock line held low by the environment
    run_seq(0, 1'b1, 0, cyc);
    check_eq("R7 failure stuck scl", int'(recovery_failed), 1);
    check_eq("R7 no ok stuck scl", int'(bus_ok), 0);

    // R8: request during a run
    run_seq(2, 1'b0, 5 * HP + 3, cyc);
    check_eq("R8 length unchanged", cyc, RUN_CYC);
    check_eq("R8 single start", starts, 1);
    check_eq("R7 ok after recovery", int'(bus_ok), 1);
    repeat (4 * HP) @(negedge clk);
    check_eq("R8 no second run", int'(busy), 0);
    check_eq("R8 no extra start", starts, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule